// File: doc/BRIEF.md
# ADC Test Pattern Inserter

This block sits in the digital output path of an analog-to-digital converter, ahead of any output bit reordering. Each cycle it either forwards the converter sample or puts a generated test word in its place. The test word is a constant or a rising ramp. The output register carries the same valid strobe as the input, delayed by one cycle. The result is then converted to two's complement or offset binary.

A single 18-bit custom word serves two purposes. In constant mode it is the pattern itself. In ramp mode it is the step added on each valid sample. Pattern words are MSB-justified to the converter's native resolution (18, 16 or 14 bits), and the bits below the native LSB are forced to zero. For that reason the step codes 1, 4 and 16 land exactly on the native LSB.

Top module: `tpat_inserter`

## Requirements
- R1: While rst_n is low, and on the first sample after reset, out_vld_o is 0 and out_dat_o is 0.
- R2: out_vld_o equals smp_vld_i delayed by one clock. out_dat_o changes only in the cycle after a cycle with smp_vld_i high, and otherwise holds its value.
- R3: With mode_i = 3'b000, a valid sample appears on out_dat_o one cycle later, unchanged when fmt_ob_i = 0.
- R4: The unused mode codes 3'b001, 3'b100, 3'b101, 3'b110 and 3'b111 behave exactly like 3'b000.
- R5: With mode_i = 3'b011, each valid sample is replaced by cust_pat_i with the bits below the native LSB cleared. res_sel_i 2'b00 selects 18 bits (no bits cleared), 2'b01 selects 16 bits (bits 1:0 cleared), 2'b10 selects 14 bits (bits 3:0 cleared), and 2'b11 acts as 2'b00.
- R6: With mode_i = 3'b010, successive valid samples output 0, S, 2S, ... modulo 2^18. S is cust_pat_i masked as in R5.
- R7: The ramp advances only on valid samples. A cycle with smp_vld_i low neither advances the ramp nor changes the output.
- R8: Entering mode 3'b010 from any other mode restarts the ramp, so the first valid sample outputs 0.
- R9: With fmt_ob_i = 1, bit 17 of the selected word is inverted, in every mode. With fmt_ob_i = 0, the word is output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld_i | input | 1 | Sample valid strobe |
| smp_dat_i | input | 18 | Converter sample, two's complement |
| mode_i | input | 3 | 000 normal, 010 ramp, 011 constant, others as normal |
| cust_pat_i | input | 18 | Constant pattern or ramp step |
| res_sel_i | input | 2 | Native resolution: 00 18-bit, 01 16-bit, 10 14-bit |
| fmt_ob_i | input | 1 | 0 two's complement, 1 offset binary |
| out_vld_o | output | 1 | Output valid, one cycle after input |
| out_dat_o | output | 18 | Output word |

## Verification
The bound assertions check the per-cycle relations on every cycle. These are valid delay, data hold on invalid cycles, unchanged pass-through, the constant at full resolution, the inversion of the top bit in offset binary, and the cleared low bits at 14-bit resolution. The ramp sequence depends on history: its start at zero, its advance on valid samples only, its restart on re-entry and its wrap at 2^18. The bench scenarios show these, together with the unused mode codes and the masking of the step at reduced resolution.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

   localparam int unsigned TP_DW = 18;

   localparam logic [2:0] TP_MODE_PASS  = 3'b000;
   localparam logic [2:0] TP_MODE_RAMP  = 3'b010;
   localparam logic [2:0] TP_MODE_CONST = 3'b011;

   localparam logic [1:0] TP_RES_FULL = 2'b00;
   localparam logic [1:0] TP_RES_MID  = 2'b01;
   localparam logic [1:0] TP_RES_LOW  = 2'b10;

   typedef enum logic [1:0] {
      SRC_SAMPLE = 2'd0,
      SRC_RAMP   = 2'd1,
      SRC_CONST  = 2'd2
   } tp_src_e;

   function automatic tp_src_e tp_decode(input logic [2:0] mode);
      case (mode)
         TP_MODE_RAMP:  return SRC_RAMP;
         TP_MODE_CONST: return SRC_CONST;
         default:       return SRC_SAMPLE;
      endcase
   endfunction

endpackage

// File: rtl/tpat_res_mask.sv
module tpat_res_mask #(
   parameter int unsigned DW     = 18,
   parameter int unsigned W_FULL = 18,
   parameter int unsigned W_MID  = 16,
   parameter int unsigned W_LOW  = 14
) (
   input  logic [1:0]    res_sel_i,
   output logic [DW-1:0] mask_o
);
   import tpat_pkg::*;

   localparam int unsigned LSB_FULL = DW - W_FULL;
   localparam int unsigned LSB_MID  = DW - W_MID;
   localparam int unsigned LSB_LOW  = DW - W_LOW;

   if (W_FULL > DW || W_MID > DW || W_LOW > DW) begin : g_bad_w
      $error("tpat_res_mask: native width exceeds data width");
   end
   if (W_LOW == 0 || W_MID == 0 || W_FULL == 0) begin : g_zero_w
      $error("tpat_res_mask: native width must be non-zero");
   end

   for (genvar i = 0; i < DW; i++) begin : g_bit
      localparam logic KEEP_FULL = (i >= LSB_FULL);
      localparam logic KEEP_MID  = (i >= LSB_MID);
      localparam logic KEEP_LOW  = (i >= LSB_LOW);
      always_comb begin
         case (res_sel_i)
            TP_RES_MID: mask_o[i] = KEEP_MID;
            TP_RES_LOW: mask_o[i] = KEEP_LOW;
            default:    mask_o[i] = KEEP_FULL;
         endcase
      end
   end

endmodule

// File: rtl/tpat_ramp_gen.sv
module tpat_ramp_gen #(
   parameter int unsigned DW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ramp_sel_i,
   input  logic          adv_i,
   input  logic [DW-1:0] step_i,
   output logic [DW-1:0] val_o
);

   if (DW < 2) begin : g_bad_dw
      $error("tpat_ramp_gen: DW must be at least 2");
   end

   logic          ramp_q;
   logic [DW-1:0] acc_q;
   logic [DW-1:0] acc_base;
   logic [DW-1:0] acc_d;

   always_comb begin
      acc_base = (ramp_sel_i && !ramp_q) ? '0 : acc_q;
      acc_d    = acc_q;
      if (ramp_sel_i) begin
         acc_d = adv_i ? (acc_base + step_i) : acc_base;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ramp_q <= 1'b0;
         acc_q  <= '0;
      end else begin
         ramp_q <= ramp_sel_i;
         acc_q  <= acc_d;
      end
   end

   assign val_o = acc_base;

endmodule

// File: rtl/tpat_out_stage.sv
module tpat_out_stage #(
   parameter int unsigned DW     = 18,
   parameter int unsigned SIGN_B = DW - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld_i,
   input  logic [DW-1:0] dat_i,
   input  logic          ob_i,
   output logic          vld_o,
   output logic [DW-1:0] dat_o
);

   if (SIGN_B >= DW) begin : g_bad_sign
      $error("tpat_out_stage: sign bit outside word");
   end

   logic [DW-1:0] flip;
   logic [DW-1:0] fmt_dat;

   for (genvar i = 0; i < DW; i++) begin : g_flip
      if (i == SIGN_B) begin : g_sign
         assign flip[i] = ob_i;
      end else begin : g_plain
         assign flip[i] = 1'b0;
      end
   end

   assign fmt_dat = dat_i ^ flip;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         dat_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            dat_o <= fmt_dat;
         end
      end
   end

endmodule

// File: rtl/tpat_inserter.sv
module tpat_inserter #(
   parameter int unsigned DW     = tpat_pkg::TP_DW,
   parameter int unsigned W_FULL = 18,
   parameter int unsigned W_MID  = 16,
   parameter int unsigned W_LOW  = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_vld_i,
   input  logic [DW-1:0] smp_dat_i,
   input  logic [2:0]    mode_i,
   input  logic [DW-1:0] cust_pat_i,
   input  logic [1:0]    res_sel_i,
   input  logic          fmt_ob_i,
   output logic          out_vld_o,
   output logic [DW-1:0] out_dat_o
);
   import tpat_pkg::*;

   if (W_LOW > W_MID || W_MID > W_FULL) begin : g_bad_order
      $error("tpat_inserter: native widths must be ordered low <= mid <= full");
   end

   tp_src_e       src;
   logic [DW-1:0] res_mask;
   logic [DW-1:0] step;
   logic [DW-1:0] ramp_val;
   logic [DW-1:0] sel_dat;

   assign src  = tp_decode(mode_i);
   assign step = cust_pat_i & res_mask;

   tpat_res_mask #(
      .DW(DW), .W_FULL(W_FULL), .W_MID(W_MID), .W_LOW(W_LOW)
   ) u_mask (
      .res_sel_i (res_sel_i),
      .mask_o    (res_mask)
   );

   tpat_ramp_gen #(.DW(DW)) u_ramp (
      .clk        (clk),
      .rst_n      (rst_n),
      .ramp_sel_i (src == SRC_RAMP),
      .adv_i      (smp_vld_i),
      .step_i     (step),
      .val_o      (ramp_val)
   );

   always_comb begin
      case (src)
         SRC_RAMP:  sel_dat = ramp_val & res_mask;
         SRC_CONST: sel_dat = cust_pat_i & res_mask;
         default:   sel_dat = smp_dat_i;
      endcase
   end

   tpat_out_stage #(.DW(DW)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (smp_vld_i),
      .dat_i (sel_dat),
      .ob_i  (fmt_ob_i),
      .vld_o (out_vld_o),
      .dat_o (out_dat_o)
   );

endmodule

// File: rtl/tpat_inserter_chk.sv
module tpat_inserter_chk #(
   parameter int unsigned DW = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_vld_i,
   input logic [DW-1:0] smp_dat_i,
   input logic [2:0]    mode_i,
   input logic [DW-1:0] cust_pat_i,
   input logic [1:0]    res_sel_i,
   input logic          fmt_ob_i,
   input logic          out_vld_o,
   input logic [DW-1:0] out_dat_o
);

   AST_VLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld_i |=> out_vld_o); // R2
   AST_VLD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld_i |=> !out_vld_o); // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld_i |=> $stable(out_dat_o)); // R7
   AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld_i && mode_i == 3'b000 && !fmt_ob_i) |=> out_dat_o == $past(smp_dat_i)); // R3
   AST_CONST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld_i && mode_i == 3'b011 && res_sel_i == 2'b00 && !fmt_ob_i)
      |=> out_dat_o == $past(cust_pat_i)); // R5
   AST_OB_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld_i && mode_i == 3'b000 && fmt_ob_i)
      |=> out_dat_o[DW-1] != $past(smp_dat_i[DW-1])); // R9
   AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld_i && (mode_i == 3'b010 || mode_i == 3'b011) && res_sel_i == 2'b10)
      |=> out_dat_o[3:0] == 4'h0); // R5

endmodule

bind tpat_inserter tpat_inserter_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_vld_i  (smp_vld_i),
   .smp_dat_i  (smp_dat_i),
   .mode_i     (mode_i),
   .cust_pat_i (cust_pat_i),
   .res_sel_i  (res_sel_i),
   .fmt_ob_i   (fmt_ob_i),
   .out_vld_o  (out_vld_o),
   .out_dat_o  (out_dat_o)
);

// File: tb/tb_tpat_inserter.sv
module tb_tpat_inserter;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        smp_vld;
   logic [17:0] smp_dat;
   logic [2:0]  mode;
   logic [17:0] cust;
   logic [1:0]  res;
   logic        fmt;
   logic        out_vld;
   logic [17:0] out_dat;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   tpat_inserter dut (
      .clk(clk), .rst_n(rst_n), .smp_vld_i(smp_vld), .smp_dat_i(smp_dat),
      .mode_i(mode), .cust_pat_i(cust), .res_sel_i(res), .fmt_ob_i(fmt),
      .out_vld_o(out_vld), .out_dat_o(out_dat)
   );

   function automatic logic [17:0] keep(input logic [1:0] r);
      case (r)
         2'b01:   return 18'h3FFFC;
         2'b10:   return 18'h3FFF0;
         default: return 18'h3FFFF;
      endcase
   endfunction

   task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
      end
   endtask

   // apply inputs at a falling edge, result is visible at the next falling edge
   task automatic cyc(input logic v, input logic [17:0] d);
      smp_vld = v;
      smp_dat = d;
      @(negedge clk);
   endtask

   task automatic idle_normal();
      mode = 3'b000;
      cyc(1'b0, 18'h0);
   endtask

   task automatic t_reset();
      chk("R1 vld in reset", {17'h0, out_vld}, 18'h0);
      chk("R1 data in reset", out_dat, 18'h0);
      rst_n = 1'b1;
      cyc(1'b0, 18'h0);
      chk("R1 vld after reset", {17'h0, out_vld}, 18'h0);
      chk("R1 data after reset", out_dat, 18'h0);
   endtask

   task automatic t_pass();
      mode = 3'b000; fmt = 1'b0;
      cyc(1'b1, 18'h2A5C3);
      chk("R3 pass", out_dat, 18'h2A5C3);
      chk("R2 vld high", {17'h0, out_vld}, 18'h1);
      cyc(1'b1, 18'h00017);
      chk("R3 pass second", out_dat, 18'h00017);
      cyc(1'b0, 18'h3FFFF);
      chk("R2 hold data", out_dat, 18'h00017);
      chk("R2 vld low", {17'h0, out_vld}, 18'h0);
   endtask

   task automatic t_unused();
      logic [2:0] codes [5] = '{3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
      cust = 18'h12345; fmt = 1'b0;
      for (int k = 0; k < 5; k++) begin
         mode = codes[k];
         cyc(1'b1, 18'h10F00 + 18'(k));
         chk("R4 unused code acts as normal", out_dat, 18'h10F00 + 18'(k));
      end
   endtask

   task automatic t_const();
      mode = 3'b011; fmt = 1'b0; cust = 18'h2BCDF;
      for (int r = 0; r < 4; r++) begin
         res = 2'(r);
         cyc(1'b1, 18'h00001);
         chk("R5 constant masked", out_dat, 18'h2BCDF & keep(2'(r)));
      end
      res = 2'b00;
   endtask

   task automatic t_ramp(input logic [1:0] r, input logic [17:0] c, input int n);
      logic [17:0] exp = 18'h0;
      idle_normal();
      res = r; cust = c; fmt = 1'b0; mode = 3'b010;
      for (int k = 0; k < n; k++) begin
         cyc(1'b1, 18'h3AAAA);
         chk("R6 ramp value", out_dat, exp & keep(r));
         exp = exp + (c & keep(r));
      end
      res = 2'b00;
   endtask

   task automatic t_ramp_gap();
      idle_normal();
      res = 2'b00; cust = 18'h00001; mode = 3'b010; fmt = 1'b0;
      cyc(1'b1, 18'h0); chk("R6 first", out_dat, 18'h0);
      cyc(1'b1, 18'h0); chk("R6 second", out_dat, 18'h1);
      cyc(1'b0, 18'h0); chk("R7 gap hold", out_dat, 18'h1);
      cyc(1'b0, 18'h0); chk("R7 gap hold 2", out_dat, 18'h1);
      cyc(1'b1, 18'h0); chk("R7 no advance on gap", out_dat, 18'h2);
      mode = 3'b000;
      cyc(1'b1, 18'h05555); chk("R8 leave ramp", out_dat, 18'h05555);
      mode = 3'b010;
      cyc(1'b1, 18'h0); chk("R8 re-entry restarts", out_dat, 18'h0);
      cyc(1'b1, 18'h0); chk("R8 after restart", out_dat, 18'h1);
      mode = 3'b011; cust = 18'h00040;
      cyc(1'b0, 18'h0);
      mode = 3'b010; cust = 18'h00001;
      cyc(1'b1, 18'h0); chk("R8 re-entry via constant mode", out_dat, 18'h0);
   endtask

   task automatic t_wrap();
      idle_normal();
      res = 2'b00; cust = 18'h20000; mode = 3'b010; fmt = 1'b0;
      cyc(1'b1, 18'h0); chk("R6 wrap start", out_dat, 18'h00000);
      cyc(1'b1, 18'h0); chk("R6 wrap half", out_dat, 18'h20000);
      cyc(1'b1, 18'h0); chk("R6 wrap modulo", out_dat, 18'h00000);
   endtask

   task automatic t_format();
      idle_normal();
      fmt = 1'b1; mode = 3'b000;
      cyc(1'b1, 18'h3FFFF); chk("R9 ob normal neg", out_dat, 18'h1FFFF);
      cyc(1'b1, 18'h00123); chk("R9 ob normal pos", out_dat, 18'h20123);
      mode = 3'b011; cust = 18'h2000C; res = 2'b01;
      cyc(1'b1, 18'h0); chk("R9 ob constant", out_dat, 18'h0000C);
      idle_normal();
      fmt = 1'b1; mode = 3'b010; cust = 18'h00004;
      cyc(1'b1, 18'h0); chk("R9 ob ramp zero", out_dat, 18'h20000);
      cyc(1'b1, 18'h0); chk("R9 ob ramp step", out_dat, 18'h20004);
      fmt = 1'b0; res = 2'b00;
   endtask

   initial begin
      rst_n = 1'b0; smp_vld = 1'b0; smp_dat = '0; mode = 3'b000;
      cust = '0; res = 2'b00; fmt = 1'b0;
      repeat (3) @(negedge clk);
      t_reset();
      t_pass();
      t_unused();
      t_const();
      t_ramp(2'b00, 18'h00001, 5);
      t_ramp(2'b01, 18'h00004, 4);
      t_ramp(2'b10, 18'h00010, 4);
      t_ramp(2'b10, 18'h00013, 3);
      t_ramp(2'b01, 18'h00001, 3);
      t_ramp_gap();
      t_wrap();
      t_format();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule